// File: doc/BRIEF.md
# Scan-Ready Datapath with Test-Safe Controls

A small sequential datapath whose every register is a multiplexed-scan flip-flop. Its parts are an accumulator, a register on a clock divided down inside the block, a result register with an asynchronous clear that another register drives, a shared bus with three enable-gated drivers, and a small register-file RAM written from that bus. In functional mode the block behaves as the plain datapath. In test mode all registers become one controllable and observable state vector that can be loaded and unloaded serially.

The test logic makes shifting safe. A dedicated test clock replaces both the primary clock and the divided clock. The internal clear is held off for the whole test session. Bus drivers are forced off while shifting, and the RAM write strobe is blocked while shifting. The scan cells are cut into several chains whenever their count exceeds a length limit, and each chain has its own serial input and output. A capture pulse with `scan_enable` low runs the functional next-state logic once, under the test clock.

Top module: `scan_datapath`

## Requirements
- R1: Each scan cell loads its functional next value on a rising edge of its clock when `scan_enable` is 0. When `scan_enable` is 1, it loads the value of the cell below it in its chain, or `scan_in[c]` for the lowest cell of chain c.
- R2: There are NCELL = 3W+5 cells, indexed 0 to NCELL-1. Chain c holds cells c*MAX_CHAIN up to min((c+1)*MAX_CHAIN, NCELL)-1. `scan_in[c]` enters the lowest cell of chain c, and `scan_out[c]` always shows its highest cell.
- R3: The cell layout is as follows. Bits 0 to W-1 are the accumulator and bits W to 2W-1 the divided-clock register. Bits 2W to 3W-1 are the result register and bit 3W is the divider toggle. Bit 3W+1 is the clear-control register. Bits 3W+2, 3W+3 and 3W+4 enable the bus drivers for the accumulator, the divided-clock register and the result register. `acc_out`, `slow_out` and `result` show the three W-bit fields.
- R4: With `test_mode` 0 and `scan_enable` 0, `test_clock` has no effect. On each rising `clk` edge the following happens:
  - the accumulator adds `din`, modulo 2^W;
  - the toggle inverts;
  - the enables load `drv_sel`;
  - the clear-control register loads `clr_in`;
  - the result register loads the bus.
  
  The divided-clock register loads the new accumulator value on each rising edge of the toggle.
- R5: With `test_mode` 1, every cell, including the divided-clock register, is clocked by `test_clock`, and `clk` edges change nothing. In a capture pulse the divided-clock register takes the accumulator value from before the pulse.
- R6: With `test_mode` 0, the result register is held at 0 while the clear-control cell is 0. With `test_mode` 1 the clear is never active, so a loaded result value survives the fall of `scan_enable`.
- R7: `bus_out` is the OR of the enabled sources and 0 when no driver is enabled. While `scan_enable` is 1 every driver is off and `bus_out` is 0.
- R8: The RAM writes `bus_out` at `waddr` on a rising edge of the active clock when `ram_we` is 1 and `scan_enable` is 0. `rd_data` shows the word at `raddr` without a clock. While `scan_enable` is 1 no write happens.
- R9: `rst_n` low clears every cell asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset of all cells |
| din | input | W | Accumulator addend |
| drv_sel | input | 3 | Next bus driver enables |
| clr_in | input | 1 | Next clear-control value (0 clears result) |
| ram_we | input | 1 | RAM write request |
| waddr | input | AW | RAM write address |
| raddr | input | AW | RAM read address |
| acc_out | output | W | Accumulator field |
| slow_out | output | W | Divided-clock register field |
| result | output | W | Result register field |
| bus_out | output | W | Shared bus value |
| rd_data | output | W | RAM read word |
| scan_enable | input | 1 | Shift select for all cells |
| test_mode | input | 1 | Test session: clock substitution and clear gating |
| test_clock | input | 1 | Clock used for shift and capture in test mode |
| scan_in | input | NCH | Serial input per chain |
| scan_out | output | NCH | Serial output per chain |

## Verification
The functional run drives random addends, one-hot-or-zero driver enables and rare clears, with writes to random RAM addresses, against a cycle model. It separates correct divided-clock timing, bus selection and clear behaviour from near misses. Test-mode rounds load chosen state vectors that differ in each chain, unload the captured state while loading the next, and check every shifted bit, so stitching, splitting and chain order are each pinned down. Directed rounds do the following:
- an all-ones accumulator that wraps in the capture pulse;
- a zero enable set, which gives the idle bus level;
- a cleared control bit, which must not clear the result until the test session ends.

Writes requested during shifting and idle `clk` edges in test mode show whether write blocking and clock substitution are in place.

// File: rtl/scan_dp_pkg.sv
`timescale 1ns/1ps
package scan_dp_pkg;
   localparam int NDRV = 3;

   function automatic int cell_count(input int w);
      return 3 * w + 2 + NDRV;
   endfunction

   function automatic int chain_count(input int n, input int m);
      return (n + m - 1) / m;
   endfunction

   function automatic int slow_lo(input int w);
      return w;
   endfunction

   function automatic int hold_lo(input int w);
      return 2 * w;
   endfunction

   function automatic int tog_bit(input int w);
      return 3 * w;
   endfunction

   function automatic int clr_bit(input int w);
      return 3 * w + 1;
   endfunction

   function automatic int drv_lo(input int w);
      return 3 * w + 2;
   endfunction
endpackage

// File: rtl/scan_cell.sv
`timescale 1ns/1ps
module scan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic se,
   input  logic si,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= se ? si : d;
   end
endmodule

// File: rtl/scan_fabric.sv
`timescale 1ns/1ps
module scan_fabric #(
   parameter int W         = 8,
   parameter int N         = 29,
   parameter int MAX_CHAIN = 16,
   localparam int NCH      = (N + MAX_CHAIN - 1) / MAX_CHAIN
) (
   input  logic           clk_main,
   input  logic           clk_slow,
   input  logic           rst_n,
   input  logic           rst_hold_n,
   input  logic           se,
   input  logic [NCH-1:0] scan_in,
   input  logic [N-1:0]   d,
   output logic [N-1:0]   q,
   output logic [NCH-1:0] scan_out
);
   localparam int SLOW_LO = scan_dp_pkg::slow_lo(W);
   localparam int HOLD_LO = scan_dp_pkg::hold_lo(W);

   for (genvar k = 0; k < N; k++) begin : g_cell
      logic cclk, crst, csi;
      if (k >= SLOW_LO && k < SLOW_LO + W) begin : g_slow
         assign cclk = clk_slow;
         assign crst = rst_n;
      end else if (k >= HOLD_LO && k < HOLD_LO + W) begin : g_hold
         assign cclk = clk_main;
         assign crst = rst_hold_n;
      end else begin : g_main
         assign cclk = clk_main;
         assign crst = rst_n;
      end
      if (k % MAX_CHAIN == 0) begin : g_head
         assign csi = scan_in[k / MAX_CHAIN];
      end else begin : g_link
         assign csi = q[k-1];
      end
      scan_cell u_cell (
         .clk  (cclk),
         .rst_n(crst),
         .se   (se),
         .si   (csi),
         .d    (d[k]),
         .q    (q[k])
      );
   end

   for (genvar c = 0; c < NCH; c++) begin : g_tail
      localparam int TOP = ((c + 1) * MAX_CHAIN < N) ? (c + 1) * MAX_CHAIN : N;
      assign scan_out[c] = q[TOP-1];
   end
endmodule

// File: rtl/bus_fabric.sv
`timescale 1ns/1ps
module bus_fabric #(
   parameter int          W        = 8,
   parameter int          NDRV     = 3,
   parameter logic [31:0] BUS_IDLE = 32'd0
) (
   input  logic [NDRV-1:0][W-1:0] src,
   input  logic [NDRV-1:0]        en_req,
   input  logic                   se,
   output logic [W-1:0]           bus
);
   logic [NDRV-1:0][W-1:0] drive;
   logic [NDRV-1:0]        en_eff;

   for (genvar i = 0; i < NDRV; i++) begin : g_drv
      assign en_eff[i] = en_req[i] & ~se;
      assign drive[i]  = en_eff[i] ? src[i] : '0;
   end

   always_comb begin
      bus = '0;
      for (int i = 0; i < NDRV; i++) bus = bus | drive[i];
      if (en_eff == '0) bus = BUS_IDLE[W-1:0];
   end
endmodule

// File: rtl/reg_file.sv
`timescale 1ns/1ps
module reg_file #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/scan_datapath.sv
`timescale 1ns/1ps
module scan_datapath #(
   parameter int          W         = 8,
   parameter int          DEPTH     = 4,
   parameter int          MAX_CHAIN = 16,
   parameter logic [31:0] BUS_IDLE  = 32'd0,
   localparam int NCELL = scan_dp_pkg::cell_count(W),
   localparam int NCH   = scan_dp_pkg::chain_count(NCELL, MAX_CHAIN),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   din,
   input  logic [2:0]     drv_sel,
   input  logic           clr_in,
   input  logic           ram_we,
   input  logic [AW-1:0]  waddr,
   input  logic [AW-1:0]  raddr,
   output logic [W-1:0]   acc_out,
   output logic [W-1:0]   slow_out,
   output logic [W-1:0]   result,
   output logic [W-1:0]   bus_out,
   output logic [W-1:0]   rd_data,
   input  logic           scan_enable,
   input  logic           test_mode,
   input  logic           test_clock,
   input  logic [NCH-1:0] scan_in,
   output logic [NCH-1:0] scan_out
);
   import scan_dp_pkg::*;

   localparam int SLOW_LO = slow_lo(W);
   localparam int HOLD_LO = hold_lo(W);
   localparam int TOG     = tog_bit(W);
   localparam int CLR     = clr_bit(W);
   localparam int DRV_LO  = drv_lo(W);

   if (W < 1 || W > 32) begin : g_bad_w
      $error("scan_datapath: W must be 1..32");
   end
   if (MAX_CHAIN < 1) begin : g_bad_chain
      $error("scan_datapath: MAX_CHAIN must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("scan_datapath: DEPTH must be a power of two of at least 2");
   end

   logic [NCELL-1:0] cell_q, cell_d;
   logic             clk_main, clk_slow, rst_hold_n;
   logic [W-1:0]     acc_q, slow_q, hold_q;
   logic [NDRV-1:0]  drv_q;
   logic             tog_q, clr_q;
   logic [NDRV-1:0][W-1:0] bus_src;

   assign acc_q  = cell_q[0 +: W];
   assign slow_q = cell_q[SLOW_LO +: W];
   assign hold_q = cell_q[HOLD_LO +: W];
   assign tog_q  = cell_q[TOG];
   assign clr_q  = cell_q[CLR];
   assign drv_q  = cell_q[DRV_LO +: NDRV];

   // clock substitution and clear gating for the test session
   assign clk_main   = test_mode ? test_clock : clk;
   assign clk_slow   = test_mode ? test_clock : tog_q;
   assign rst_hold_n = rst_n & (clr_q | test_mode);

   // functional next-state values
   assign cell_d[0 +: W]          = acc_q + din;
   assign cell_d[SLOW_LO +: W]    = acc_q;
   assign cell_d[HOLD_LO +: W]    = bus_out;
   assign cell_d[TOG]             = ~tog_q;
   assign cell_d[CLR]             = clr_in;
   assign cell_d[DRV_LO +: NDRV]  = drv_sel;

   scan_fabric #(.W(W), .N(NCELL), .MAX_CHAIN(MAX_CHAIN)) u_fabric (
      .clk_main  (clk_main),
      .clk_slow  (clk_slow),
      .rst_n     (rst_n),
      .rst_hold_n(rst_hold_n),
      .se        (scan_enable),
      .scan_in   (scan_in),
      .d         (cell_d),
      .q         (cell_q),
      .scan_out  (scan_out)
   );

   assign bus_src[0] = acc_q;
   assign bus_src[1] = slow_q;
   assign bus_src[2] = hold_q;

   bus_fabric #(.W(W), .NDRV(NDRV), .BUS_IDLE(BUS_IDLE)) u_bus (
      .src   (bus_src),
      .en_req(drv_q),
      .se    (scan_enable),
      .bus   (bus_out)
   );

   reg_file #(.W(W), .DEPTH(DEPTH)) u_rf (
      .clk  (clk_main),
      .we   (ram_we & ~scan_enable),
      .waddr(waddr),
      .wdata(bus_out),
      .raddr(raddr),
      .rdata(rd_data)
   );

   assign acc_out  = acc_q;
   assign slow_out = slow_q;
   assign result   = hold_q;
endmodule

// File: rtl/scan_datapath_chk.sv
`timescale 1ns/1ps
module scan_datapath_chk #(
   parameter int          W         = 8,
   parameter int          MAX_CHAIN = 16,
   parameter int          N         = 29,
   parameter int          AW        = 2,
   parameter logic [31:0] BUS_IDLE  = 32'd0
) (
   input logic          clk_main,
   input logic          rst_n,
   input logic          test_mode,
   input logic          scan_enable,
   input logic [N-1:0]  cell_q,
   input logic [W-1:0]  bus_out,
   input logic [W-1:0]  rd_data,
   input logic [AW-1:0] raddr
);
   localparam int SLOW_LO = scan_dp_pkg::slow_lo(W);
   localparam int HOLD_LO = scan_dp_pkg::hold_lo(W);
   localparam int CLR     = scan_dp_pkg::clr_bit(W);

   for (genvar k = 1; k < N; k++) begin : g_link
      if (k % MAX_CHAIN != 0) begin : g_chk
         // R1
         shift_link_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
            (test_mode && $past(test_mode) && $past(scan_enable)) |-> cell_q[k] == $past(cell_q[k-1]));
      end
   end

   // R5
   slow_capture_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
      (test_mode && $past(test_mode) && !$past(scan_enable))
         |-> cell_q[SLOW_LO +: W] == $past(cell_q[0 +: W]));

   // R6
   hold_capture_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
      (test_mode && $past(test_mode) && !$past(scan_enable))
         |-> cell_q[HOLD_LO +: W] == $past(bus_out));

   // R6
   hold_clear_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
      (!test_mode && !cell_q[CLR]) |-> cell_q[HOLD_LO +: W] == '0);

   // R7
   bus_idle_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
      scan_enable |-> bus_out == BUS_IDLE[W-1:0]);

   // R8
   ram_hold_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
      (scan_enable && $past(scan_enable) && $stable(raddr)) |-> $stable(rd_data));
endmodule

bind scan_datapath scan_datapath_chk #(
   .W(W), .MAX_CHAIN(MAX_CHAIN), .N(NCELL), .AW(AW), .BUS_IDLE(BUS_IDLE)
) u_chk (
   .clk_main   (clk_main),
   .rst_n      (rst_n),
   .test_mode  (test_mode),
   .scan_enable(scan_enable),
   .cell_q     (cell_q),
   .bus_out    (bus_out),
   .rd_data    (rd_data),
   .raddr      (raddr)
);

// File: tb/scan_datapath_tb.sv
`timescale 1ns/1ps
module scan_datapath_tb;
   localparam int W     = 8;
   localparam int DEPTH = 4;
   localparam int MAXC  = 16;
   localparam int N     = 3 * W + 5;
   localparam int NCH   = (N + MAXC - 1) / MAXC;
   localparam int AW    = 2;
   localparam int SL    = W;
   localparam int HL    = 2 * W;
   localparam int TG    = 3 * W;
   localparam int CL    = 3 * W + 1;
   localparam int DL    = 3 * W + 2;
   localparam int LMAX  = (N < MAXC) ? N : MAXC;

   logic clk = 0, rst_n = 1, test_clock = 0, test_mode = 0, scan_enable = 0;
   logic [W-1:0] din = 0;
   logic [2:0] drv_sel = 0;
   logic clr_in = 1, ram_we = 0;
   logic [AW-1:0] waddr = 0, raddr = 0;
   logic [NCH-1:0] scan_in = 0;
   logic [W-1:0] acc_out, slow_out, result, bus_out, rd_data;
   logic [NCH-1:0] scan_out;

   int total = 0, bad = 0;
   bit done = 0;
   logic [N-1:0] ms;
   logic [W-1:0] mem [DEPTH];
   bit valid [DEPTH];

   always #2.5 clk = ~clk;

   scan_datapath #(.W(W), .DEPTH(DEPTH), .MAX_CHAIN(MAXC)) u_dut (
      .clk(clk), .rst_n(rst_n), .din(din), .drv_sel(drv_sel), .clr_in(clr_in),
      .ram_we(ram_we), .waddr(waddr), .raddr(raddr), .acc_out(acc_out),
      .slow_out(slow_out), .result(result), .bus_out(bus_out), .rd_data(rd_data),
      .scan_enable(scan_enable), .test_mode(test_mode), .test_clock(test_clock),
      .scan_in(scan_in), .scan_out(scan_out)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int chain_top(input int c);
      return (((c + 1) * MAXC < N) ? (c + 1) * MAXC : N) - 1;
   endfunction

   function automatic logic [W-1:0] f_bus(input logic [N-1:0] s, input logic se);
      logic [W-1:0] r = '0;
      if (!se) begin
         if (s[DL])   r = r | s[0 +: W];
         if (s[DL+1]) r = r | s[SL +: W];
         if (s[DL+2]) r = r | s[HL +: W];
      end
      return r;
   endfunction

   function automatic logic [N-1:0] f_next(input logic [N-1:0] s, input logic [W-1:0] a,
                                           input logic [2:0] dv, input logic cl, input logic tm);
      logic [N-1:0] n = s;
      n[0 +: W]  = s[0 +: W] + a;
      n[TG]      = ~s[TG];
      n[CL]      = cl;
      n[DL +: 3] = dv;
      if (tm) begin
         n[SL +: W] = s[0 +: W];
         n[HL +: W] = f_bus(s, 1'b0);
      end else begin
         if (!s[TG]) n[SL +: W] = n[0 +: W];
         n[HL +: W] = (s[CL] && cl) ? f_bus(s, 1'b0) : '0;
      end
      return n;
   endfunction

   function automatic logic [N-1:0] f_shift(input logic [N-1:0] s, input logic [NCH-1:0] si);
      logic [N-1:0] n;
      for (int k = 0; k < N; k++) n[k] = (k % MAXC == 0) ? si[k / MAXC] : s[k-1];
      return n;
   endfunction

   function automatic logic [2:0] pick_drv();
      case ($urandom % 4)
         0: return 3'b000;
         1: return 3'b001;
         2: return 3'b010;
         default: return 3'b100;
      endcase
   endfunction

   task automatic pulse_tck();
      #1 test_clock = 1;
      #2 test_clock = 0;
      #2;
   endtask

   task automatic shift_one(input logic [NCH-1:0] si);
      scan_in = si;
      #1;
      for (int c = 0; c < NCH; c++) chk("R2", "scan_out", scan_out[c], ms[chain_top(c)]);
      chk("R7", "bus during shift", bus_out, 0);
      chk("R8", "ram during shift", rd_data, mem[raddr]);
      pulse_tck();
      ms = f_shift(ms, si);
   endtask

   task automatic load_vector(input logic [N-1:0] tgt);
      for (int t = 0; t < LMAX; t++) begin
         logic [NCH-1:0] si;
         for (int c = 0; c < NCH; c++) begin
            int j = LMAX - 1 - t;
            int lo = c * MAXC;
            si[c] = (lo + j <= chain_top(c)) ? tgt[lo + j] : 1'b0;
         end
         shift_one(si);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      #1 rst_n = 0;
      #6;
      // R9: reset state
      chk("R9", "acc reset", acc_out, 0);
      chk("R9", "slow reset", slow_out, 0);
      chk("R9", "result reset", result, 0);
      chk("R9", "bus reset", bus_out, 0);
      chk("R9", "scan_out reset", scan_out, 0);
      ms = '0;
      for (int i = 0; i < DEPTH; i++) valid[i] = 0;

      // R4: functional mode against the cycle model
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] b;
         din     = W'($urandom);
         drv_sel = pick_drv();
         clr_in  = ($urandom % 8) != 0;
         ram_we  = (i < DEPTH) ? 1'b1 : 1'($urandom);
         waddr   = (i < DEPTH) ? AW'(i) : AW'($urandom);
         raddr   = AW'($urandom);
         test_clock = 1'($urandom);
         b = f_bus(ms, 1'b0);
         if (ram_we) begin mem[waddr] = b; valid[waddr] = 1; end
         ms = f_next(ms, din, drv_sel, clr_in, 1'b0);
         @(negedge clk);
         test_clock = 0;
         chk("R4", "acc", acc_out, ms[0 +: W]);
         chk("R4", "slow", slow_out, ms[SL +: W]);
         chk("R6", "result", result, ms[HL +: W]);
         chk("R7", "bus", bus_out, f_bus(ms, 1'b0));
         if (valid[raddr]) chk("R8", "ram read", rd_data, mem[raddr]);
      end

      // R5: enter test mode, clk edges must change nothing
      ram_we = 0;
      test_mode = 1;
      repeat (3) @(negedge clk);
      chk("R5", "acc held under clk", acc_out, ms[0 +: W]);
      chk("R5", "slow held under clk", slow_out, ms[SL +: W]);

      scan_enable = 1;
      ram_we = 1;
      waddr = AW'($urandom);
      raddr = waddr;
      for (int r = 0; r < 5; r++) begin
         logic [N-1:0] tgt;
         for (int k = 0; k < N; k++) tgt[k] = 1'($urandom);
         tgt[DL +: 3] = pick_drv();
         if (r == 0) begin tgt[0 +: W] = '1; tgt[CL] = 0; tgt[DL +: 3] = 3'b100; end
         if (r == 1) tgt[DL +: 3] = 3'b000;
         if (r == 4) begin tgt = '0; tgt[HL +: W] = W'(8'hA5); end
         load_vector(tgt);
         chk("R2", "acc loaded", acc_out, tgt[0 +: W]);
         chk("R3", "slow loaded", slow_out, tgt[SL +: W]);
         chk("R3", "result loaded", result, tgt[HL +: W]);
         if (r < 4) begin
            scan_enable = 0;
            ram_we = 0;
            #1;
            chk("R6", "result kept after se fall", result, ms[HL +: W]);
            din = (r == 0) ? W'(1) : W'($urandom);
            drv_sel = pick_drv();
            clr_in = 1'($urandom);
            begin
               logic [N-1:0] e;
               e = f_next(ms, din, drv_sel, clr_in, 1'b1);
               pulse_tck();
               ms = e;
            end
            chk("R1", "acc capture", acc_out, ms[0 +: W]);
            chk("R5", "slow capture", slow_out, ms[SL +: W]);
            chk("R1", "result capture", result, ms[HL +: W]);
            chk("R7", "bus after capture", bus_out, f_bus(ms, 1'b0));
            scan_enable = 1;
            ram_we = 1;
         end
      end

      // R6: leaving test mode restores the internal clear
      scan_enable = 0;
      ram_we = 0;
      #1;
      chk("R6", "result before exit", result, W'(8'hA5));
      @(negedge clk);
      test_mode = 0;
      #1;
      chk("R6", "result cleared after exit", result, 0);
      rst_n = 0;
      #2;
      chk("R9", "acc async reset", acc_out, 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule